// File: doc/BRIEF.md
# Debug Exception Cause Unit

This unit sits at the retire stage of a processor core and decides whether the instruction now retiring enters the debug exception. It gathers five kinds of debug event: the wide and narrow software break instructions, an instruction-address breakpoint hit, a data-breakpoint hit tagged with the index of the matching comparator, and the overflow of an internal retired-instruction counter. A debug event is taken only while the current interrupt level is below the fixed debug level of 6. At level 6 or above the event is dropped and the instruction retires normally.

On entry the unit raises a one-cycle take strobe. It loads the low status bits with the exception-mode flag and level 6, saves the PC of the instruction that caused the event (not the PC of the next one), and overwrites a one-hot cause register. The low status bits live in this unit, and software loads them through a write port. Because entry raises the level to 6, further events are ignored until software writes a lower level back.

The retired-instruction counter can be loaded by software. It counts retirements only while the interrupt level is below a programmable count level. An overflow from all-ones arms a count event that fires on the next retiring instruction.

Top module: `dbg_cause_unit`

## Requirements
- R1: An event is taken only when a retiring instruction carries one and the level in `ps_low[3:0]` is below 6. Otherwise `take_dbg` stays low and `ps_low`, `saved_pc` and `dbg_cause` keep their values.
- R2: When an event is taken, `ps_low` becomes 5'h16 on the next cycle: bit 4 is the exception-mode flag and bits [3:0] hold level 6.
- R3: When an event is taken, `saved_pc` receives the `retire_pc` of the instruction that caused it.
- R4: `dbg_cause[4:0]` is one-hot and is overwritten on each entry: 0x01 count overflow, 0x02 instruction breakpoint, 0x04 data breakpoint, 0x08 wide break, 0x10 narrow break. Bits [7:5] read zero.
- R5: For a data-breakpoint entry, `dbrk_idx` is written to `dbg_cause[11:8]`. For every other cause these bits are zero.
- R6: When several events fall on one instruction, only the highest one is reported. The order is count overflow, then instruction breakpoint, then data breakpoint, then wide break, then narrow break.
- R7: `icnt_value` increases by one for each retiring instruction that is not taken, but only while `ps_low[3:0]` is below `icnt_level`. A write on `icnt_wr_en` loads it instead.
- R8: An increment from all-ones arms a count event. The next retiring instruction takes the debug exception with cause 0x01 and is itself not counted.
- R9: After reset, `take_dbg`, `ps_low`, `saved_pc`, `dbg_cause` and `icnt_value` are zero. `take_dbg` is high for exactly one cycle per entry. `ps_wr_en` loads `ps_low` from `ps_wr_data` when no entry happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_valid | input | 1 | An instruction retires this cycle |
| retire_pc | input | AW | PC of the retiring instruction |
| brk_wide | input | 1 | Retiring instruction is a wide break |
| brk_narrow | input | 1 | Retiring instruction is a narrow break |
| ibrk_hit | input | 1 | Enabled instruction breakpoint matches retiring PC |
| dbrk_hit | input | 1 | Data breakpoint matched the retiring access |
| dbrk_idx | input | 4 | Index of the matching data comparator |
| ps_wr_en | input | 1 | Software write of the low status bits |
| ps_wr_data | input | 5 | Value for the low status bits |
| icnt_wr_en | input | 1 | Software load of the instruction counter |
| icnt_wr_data | input | CW | Load value for the instruction counter |
| icnt_level | input | 4 | Counting happens while level is below this |
| take_dbg | output | 1 | One-cycle strobe on debug entry |
| ps_low | output | 5 | Exception-mode flag and interrupt level |
| saved_pc | output | AW | Return PC saved on entry |
| dbg_cause | output | 12 | Cause register |
| icnt_value | output | CW | Instruction counter |

## Verification
The count overflow can fall on the same instruction as a breakpoint or a break instruction. The bench preloads the counter two short of wrap, retires two plain instructions to arm the count event, and then retires one that also carries an instruction-breakpoint hit and a wide break. It expects only cause 0x01, the PC of that third instruction, and a counter that does not advance. Collisions among the other sources are walked through the table by setting several event inputs on one instruction and comparing the single reported cause.

// File: rtl/dbg_cause_pkg.sv
package dbg_cause_pkg;
  localparam int LVL_W   = 4;
  localparam int IDX_W   = 4;
  localparam int CAUSE_W = 12;
  localparam logic [LVL_W-1:0] DBG_LVL  = 4'd6;
  localparam logic [4:0]       PS_ENTRY = 5'h10 | 5'(DBG_LVL);
  // one-hot cause codes, bits [4:0] of the cause register
  localparam logic [4:0] C_ICNT = 5'h01;
  localparam logic [4:0] C_IBRK = 5'h02;
  localparam logic [4:0] C_DBRK = 5'h04;
  localparam logic [4:0] C_BRKW = 5'h08;
  localparam logic [4:0] C_BRKN = 5'h10;
endpackage

// File: rtl/dbg_cause_sel.sv
module dbg_cause_sel
  import dbg_cause_pkg::*;
(
  input  logic             icnt_ev,
  input  logic             ibrk,
  input  logic             dbrk,
  input  logic             brkw,
  input  logic             brkn,
  input  logic [IDX_W-1:0] idx,
  output logic             any_ev,
  output logic [CAUSE_W-1:0] cause
);
  logic [4:0]       code;
  logic [IDX_W-1:0] fld;

  // fixed priority, highest first
  always_comb begin
    code = 5'h00;
    fld  = '0;
    if (icnt_ev)   code = C_ICNT;
    else if (ibrk) code = C_IBRK;
    else if (dbrk) begin
      code = C_DBRK;
      fld  = idx;
    end
    else if (brkw) code = C_BRKW;
    else if (brkn) code = C_BRKN;
  end

  assign any_ev = |code;
  assign cause  = {fld, 3'b000, code};
endmodule

// File: rtl/dbg_icount.sv
module dbg_icount #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  input  logic          retire,
  input  logic          taken,
  input  logic          lvl_ok,
  output logic [CW-1:0] cnt_q,
  output logic          pend_q
);
  localparam logic [CW-1:0] ALL_ONES = '1;
  logic inc;

  assign inc = retire && !taken && lvl_ok && !wr_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (wr_en)    cnt_q <= wr_data;
      else if (inc) cnt_q <= cnt_q + 1'b1;
      if (retire) pend_q <= 1'b0;
      if (inc && cnt_q == ALL_ONES) pend_q <= 1'b1;
    end
  end

  a_r8_arm_from_wrap: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> $past(cnt_q) == ALL_ONES);

  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !inc) |=> $stable(cnt_q));
endmodule

// File: rtl/dbg_cause_unit.sv
module dbg_cause_unit
  import dbg_cause_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               retire_valid,
  input  logic [AW-1:0]      retire_pc,
  input  logic               brk_wide,
  input  logic               brk_narrow,
  input  logic               ibrk_hit,
  input  logic               dbrk_hit,
  input  logic [IDX_W-1:0]   dbrk_idx,
  input  logic               ps_wr_en,
  input  logic [4:0]         ps_wr_data,
  input  logic               icnt_wr_en,
  input  logic [CW-1:0]      icnt_wr_data,
  input  logic [LVL_W-1:0]   icnt_level,
  output logic               take_dbg,
  output logic [4:0]         ps_low,
  output logic [AW-1:0]      saved_pc,
  output logic [CAUSE_W-1:0] dbg_cause,
  output logic [CW-1:0]      icnt_value
);
  logic [LVL_W-1:0]   cur_lvl;
  logic               icnt_pend;
  logic               any_ev;
  logic [CAUSE_W-1:0] next_cause;
  logic               take_now;

  assign cur_lvl  = ps_low[LVL_W-1:0];
  assign take_now = retire_valid && any_ev && (cur_lvl < DBG_LVL);

  dbg_cause_sel u_sel (
    .icnt_ev (icnt_pend),
    .ibrk    (ibrk_hit),
    .dbrk    (dbrk_hit),
    .brkw    (brk_wide),
    .brkn    (brk_narrow),
    .idx     (dbrk_idx),
    .any_ev  (any_ev),
    .cause   (next_cause)
  );

  dbg_icount #(.CW(CW)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (icnt_wr_en),
    .wr_data (icnt_wr_data),
    .retire  (retire_valid),
    .taken   (take_now),
    .lvl_ok  (cur_lvl < icnt_level),
    .cnt_q   (icnt_value),
    .pend_q  (icnt_pend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_dbg  <= 1'b0;
      ps_low    <= '0;
      saved_pc  <= '0;
      dbg_cause <= '0;
    end else begin
      take_dbg <= take_now;
      if (take_now) begin
        ps_low    <= PS_ENTRY;
        saved_pc  <= retire_pc;
        dbg_cause <= next_cause;
      end else if (ps_wr_en) begin
        ps_low <= ps_wr_data;
      end
    end
  end

  a_r1_level_gate: assert property (@(posedge clk) disable iff (rst)
    take_dbg |-> $past(ps_low[LVL_W-1:0]) < DBG_LVL);

  a_r2_entry_status: assert property (@(posedge clk) disable iff (rst)
    take_dbg |-> ps_low == PS_ENTRY);

  a_r3_saved_pc: assert property (@(posedge clk) disable iff (rst)
    take_dbg |-> saved_pc == $past(retire_pc));

  a_r4_one_hot: assert property (@(posedge clk) disable iff (rst)
    take_dbg |-> ($countones(dbg_cause[4:0]) == 1 && dbg_cause[7:5] == 3'b000));

  a_r5_idx_only_data: assert property (@(posedge clk) disable iff (rst)
    (take_dbg && !dbg_cause[2]) |-> dbg_cause[11:8] == '0);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    take_dbg |=> !take_dbg);
endmodule

// File: tb/dbg_cause_unit_tb.sv
module dbg_cause_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int CW = 32;
  localparam int NV = 13;
  // vector: lvl[27:24] idx[23:20] evt{ibrk,dbrk,wide,narrow}[19:16] take[12] cause[11:0]
  localparam logic [27:0] VEC [NV] = '{
    28'h0021008, 28'h5011010, 28'h6020000, 28'h7080000,
    28'h2081002, 28'h1341304, 28'h0F41F04, 28'h30A1002,
    28'h45D1002, 28'h0961904, 28'h0031008, 28'h5000000,
    28'hF740000
  };

  logic clk = 1'b0, rst = 1'b1;
  logic retire_valid = 0, brk_wide = 0, brk_narrow = 0, ibrk_hit = 0, dbrk_hit = 0;
  logic [AW-1:0] retire_pc = '0;
  logic [3:0] dbrk_idx = '0;
  logic ps_wr_en = 0;
  logic [4:0] ps_wr_data = '0;
  logic icnt_wr_en = 0;
  logic [CW-1:0] icnt_wr_data = '0;
  logic [3:0] icnt_level = '0;
  logic take_dbg;
  logic [4:0] ps_low;
  logic [AW-1:0] saved_pc;
  logic [11:0] dbg_cause;
  logic [CW-1:0] icnt_value;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_cause_unit #(.AW(AW), .CW(CW)) u_dut (.*);

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic ps_write(input logic [4:0] v);
    @(negedge clk); ps_wr_en = 1; ps_wr_data = v;
    @(negedge clk); ps_wr_en = 0;
  endtask

  task automatic retire(input logic [AW-1:0] pc, input logic [3:0] evt, input logic [3:0] idx);
    @(negedge clk);
    retire_valid = 1; retire_pc = pc;
    {ibrk_hit, dbrk_hit, brk_wide, brk_narrow} = evt; dbrk_idx = idx;
    @(negedge clk);
    retire_valid = 0; {ibrk_hit, dbrk_hit, brk_wide, brk_narrow} = 4'h0; dbrk_idx = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %h expected %h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] last_cause;
    logic [AW-1:0] last_pc;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9 reset state
    chk(take_dbg == 0 && ps_low == 0, "R9 reset take/ps", {27'd0, take_dbg, ps_low}, 0);
    chk(saved_pc == 0 && dbg_cause == 0 && icnt_value == 0, "R9 reset pc/cause/count",
        {20'd0, dbg_cause}, 0);
    last_cause = '0; last_pc = '0;

    for (int i = 0; i < NV; i++) begin
      logic [AW-1:0] pc;
      pc = 32'h1000 + 32'(i * 4);
      ps_write({1'b0, VEC[i][27:24]});
      retire(pc, VEC[i][19:16], VEC[i][23:20]);
      chk(take_dbg == VEC[i][12], "R1 take strobe", {31'd0, take_dbg}, {31'd0, VEC[i][12]});
      if (VEC[i][12]) begin
        chk(dbg_cause == VEC[i][11:0], "R4 R5 R6 cause", {20'd0, dbg_cause}, {20'd0, VEC[i][11:0]});
        chk(ps_low == 5'h16, "R2 entry status", {27'd0, ps_low}, 32'h16);
        chk(saved_pc == pc, "R3 saved pc", saved_pc, pc);
        last_cause = VEC[i][11:0]; last_pc = pc;
        @(negedge clk);
        chk(take_dbg == 0, "R9 single pulse", {31'd0, take_dbg}, 0);
      end else begin
        chk(ps_low == {1'b0, VEC[i][27:24]}, "R1 status kept", {27'd0, ps_low}, {28'd0, VEC[i][27:24]});
        chk(dbg_cause == last_cause && saved_pc == last_pc, "R1 cause/pc kept",
            {20'd0, dbg_cause}, {20'd0, last_cause});
      end
    end

    // R1: after entry level is 6, so a break is ignored until status is lowered
    ps_write(5'h02);
    retire(32'h2000, 4'h2, 4'h0);
    chk(take_dbg == 1 && ps_low == 5'h16, "R1 taken at level 2", {27'd0, ps_low}, 32'h16);
    retire(32'h2004, 4'h1, 4'h0);
    chk(take_dbg == 0 && saved_pc == 32'h2000, "R1 ignored at level 6", saved_pc, 32'h2000);
    ps_write(5'h00);
    retire(32'h2008, 4'h1, 4'h0);
    chk(take_dbg == 1 && dbg_cause == 12'h010, "R4 rearmed narrow", {20'd0, dbg_cause}, 32'h10);

    // R7 R8: counter overflow collides with breakpoint and break on one instruction
    icnt_level = 4'd1;
    ps_write(5'h00);
    @(negedge clk); icnt_wr_en = 1; icnt_wr_data = 32'hFFFF_FFFE;
    @(negedge clk); icnt_wr_en = 0;
    chk(icnt_value == 32'hFFFF_FFFE, "R7 counter load", icnt_value, 32'hFFFF_FFFE);
    retire(32'h3000, 4'h0, 4'h0);
    chk(icnt_value == 32'hFFFF_FFFF && take_dbg == 0, "R7 count step", icnt_value, 32'hFFFF_FFFF);
    retire(32'h3004, 4'h0, 4'h0);
    chk(icnt_value == 0 && take_dbg == 0, "R8 wrap no entry yet", icnt_value, 0);
    retire(32'h3008, 4'hA, 4'h0);
    chk(take_dbg == 1 && dbg_cause == 12'h001, "R8 R6 count event wins", {20'd0, dbg_cause}, 1);
    chk(saved_pc == 32'h3008, "R3 count event pc", saved_pc, 32'h3008);
    chk(icnt_value == 0, "R8 taken instr not counted", icnt_value, 0);
    retire(32'h300C, 4'h0, 4'h0);
    chk(icnt_value == 0, "R7 no count at level above limit", icnt_value, 0);
    ps_write(5'h00);
    retire(32'h3010, 4'h0, 4'h0);
    chk(icnt_value == 1 && take_dbg == 0, "R7 counts below limit, R8 event consumed", icnt_value, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule